// File: doc/BRIEF.md
# Interrupt-Gated Bus Master Arbiter

This block decides which of several bus masters owns a shared system bus. There are three gated masters: a DMA engine, an Ethernet MAC and a USB host. The processor is the fourth master and is always present. Each gated master carries two gating enables, one tied to the normal interrupt level and one tied to the fast interrupt level. While an enable is set and its interrupt is high, the arbiter treats that master as if it were not requesting. If the master holds the bus, it loses the grant at the next bus-cycle boundary. Its requests are considered again once the interrupt falls.

Arbitration uses a fixed priority among the eligible requests. The processor takes the bus whenever no eligible gated request is pending. The grant register changes only on cycles where the bus reports a completed beat, so a transfer in flight is never cut mid-beat. The enables sit in a small register with a single-cycle write strobe and a continuous read-back.

Top module: `igarb_top`

## Requirements
- R1: After reset all six gating enables read 0, and the grant selects the processor (gnt_o = 4'b1000).
- R2: A cycle with cfg_we_i high stores cfg_wdata_i into the enables, and cfg_rdata_o shows the stored value from the next cycle on. Bits [2:0] are the normal-interrupt enables and bits [5:3] are the fast-interrupt enables. Within each group, bit 0 is DMA, bit 1 is MAC and bit 2 is USB host.
- R3: Exactly one bit of gnt_o is high in every cycle. Bit 0 is DMA, bit 1 is MAC, bit 2 is USB host and bit 3 is the processor.
- R4: gnt_o changes only on the clock edge that ends a cycle in which ready_i was high. In any other cycle it holds its value.
- R5: At a boundary the arbiter grants the highest-priority eligible request. The order is DMA, then MAC, then USB host.
- R6: At a boundary with no eligible gated request, the processor is granted.
- R7: A gated master whose normal-interrupt enable is set is not eligible while irq_i is high. If it holds the grant, it loses it at the next boundary.
- R8: A gated master whose fast-interrupt enable is set is not eligible while fiq_i is high. If it holds the grant, it loses it at the next boundary.
- R9: Once the gating interrupt falls, the master's request is eligible again at the next boundary.
- R10: Gating one master leaves the choice among the other masters exactly as the fixed priority gives it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 3 | Requests of the gated masters (0 DMA, 1 MAC, 2 USB host) |
| irq_i | input | 1 | Normal interrupt level |
| fiq_i | input | 1 | Fast interrupt level |
| ready_i | input | 1 | Bus-cycle boundary: the current beat completes |
| cfg_we_i | input | 1 | Enable register write strobe |
| cfg_wdata_i | input | 6 | Enable register write data |
| cfg_rdata_o | output | 6 | Enable register read-back |
| gnt_o | output | 4 | One-hot grant (3 = processor) |

## Verification
The hardest situation to reach is a forced degrant that coincides with competing requests. In that case the gated master holds the bus, its enable is set, the matching interrupt rises, and a lower-priority master must then inherit the bus rather than the processor. The bench gets there by sweeping every enable pattern against every request pattern and both interrupt levels. Before each decision it parks the grant with ready_i low and checks that the grant holds. It then runs a targeted sequence in which a granted DMA is gated and the interrupt is later released.

// File: rtl/igarb_pkg.sv
package igarb_pkg;
    // number of gated masters; the processor is one extra master above them
    localparam int unsigned GATED_MASTERS = 3;

    // priority index of each gated master (lower index wins)
    typedef enum logic [1:0] {
        MST_DMA = 2'd0,
        MST_MAC = 2'd1,
        MST_USB = 2'd2
    } master_idx_e;
endpackage

// File: rtl/igarb_gate_mask.sv
module igarb_gate_mask #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0]   irq_en_i,
    input  logic [N-1:0]   fiq_en_i,
    input  logic           irq_i,
    input  logic           fiq_i,
    input  logic [N-1:0]   req_i,
    output logic [N-1:0]   mask_o,
    output logic [N-1:0]   elig_o
);
    // one gating cell per master
    for (genvar g = 0; g < N; g++) begin : g_cell
        always_comb begin
            mask_o[g] = (irq_en_i[g] & irq_i) | (fiq_en_i[g] & fiq_i);
            elig_o[g] = req_i[g] & ~mask_o[g];
        end
    end
endmodule

// File: rtl/igarb_prio_pick.sv
module igarb_prio_pick #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] elig_i,
    output logic [N:0]   pick_o
);
    // blocked[k]: some master with index below k is eligible
    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar k = 0; k < N; k++) begin : g_chain
        assign blocked[k+1] = blocked[k] | elig_i[k];
        assign pick_o[k]    = elig_i[k] & ~blocked[k];
    end

    // processor is the fallback owner
    assign pick_o[N] = ~blocked[N];
endmodule

// File: rtl/igarb_top.sv
module igarb_top
    import igarb_pkg::*;
#(
    parameter int unsigned N = GATED_MASTERS
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N-1:0]     req_i,
    input  logic             irq_i,
    input  logic             fiq_i,
    input  logic             ready_i,
    input  logic             cfg_we_i,
    input  logic [2*N-1:0]   cfg_wdata_i,
    output logic [2*N-1:0]   cfg_rdata_o,
    output logic [N:0]       gnt_o
);
    localparam int unsigned EN_W  = 2 * N;
    localparam int unsigned GNT_W = N + 1;
    localparam logic [GNT_W-1:0] GNT_CPU = GNT_W'(1) << N;

    typedef struct packed {
        logic [EN_W-1:0]  en;
        logic [GNT_W-1:0] gnt;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]     mask;
    logic [N-1:0]     elig;
    logic [GNT_W-1:0] pick;

    igarb_gate_mask #(.N(N)) i_mask (
        .irq_en_i (st_q.en[N-1:0]),
        .fiq_en_i (st_q.en[EN_W-1:N]),
        .irq_i    (irq_i),
        .fiq_i    (fiq_i),
        .req_i    (req_i),
        .mask_o   (mask),
        .elig_o   (elig)
    );

    igarb_prio_pick #(.N(N)) i_pick (
        .elig_i (elig),
        .pick_o (pick)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_we_i) begin
            st_d.en = cfg_wdata_i;
        end
        if (ready_i) begin
            st_d.gnt = pick;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.en  <= '0;
            st_q.gnt <= GNT_CPU;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rdata_o = st_q.en;
    assign gnt_o       = st_q.gnt;

    // R3
    gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(gnt_o) == 1);

    // R4
    gnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_i |=> $stable(gnt_o));

    // R2
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_we_i |=> $stable(cfg_rdata_o));

    // R6
    cpu_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_i && elig == '0) |=> gnt_o[N]);

    // R7 R8
    for (genvar m = 0; m < N; m++) begin : g_chk
        masked_degrant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ready_i && mask[m]) |=> !gnt_o[m]);
    end
endmodule

// File: tb/test_igarb_top.sv
`timescale 1ns/1ps
module test_igarb_top;
    localparam int N = 3;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic [N-1:0] req_i = '0;
    logic         irq_i = 1'b0;
    logic         fiq_i = 1'b0;
    logic         ready_i = 1'b0;
    logic         cfg_we_i = 1'b0;
    logic [2*N-1:0] cfg_wdata_i = '0;
    logic [2*N-1:0] cfg_rdata_o;
    logic [N:0]   gnt_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk_i = ~clk_i;

    igarb_top i_igarb_top (
        .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .irq_i(irq_i),
        .fiq_i(fiq_i), .ready_i(ready_i), .cfg_we_i(cfg_we_i),
        .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .gnt_o(gnt_o)
    );

    function automatic logic [N:0] model(input logic [5:0] en, input logic irq,
                                         input logic fiq, input logic [2:0] req);
        logic [2:0] msk, el;
        msk = (en[2:0] & {3{irq}}) | (en[5:3] & {3{fiq}});
        el  = req & ~msk;
        if (el[0])      return 4'b0001;
        else if (el[1]) return 4'b0010;
        else if (el[2]) return 4'b0100;
        else            return 4'b1000;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] v);
        @(negedge clk_i);
        cfg_we_i = 1'b1; cfg_wdata_i = v; ready_i = 1'b0;
        @(negedge clk_i);
        cfg_we_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [N:0] prev, exp;
        logic [2:0] m;
        repeat (3) @(negedge clk_i);
        // R1 reset state
        check("R1 enables", 8'(cfg_rdata_o), 8'h00);
        check("R1 grant", 8'(gnt_o), 8'b1000);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 grant after release", 8'(gnt_o), 8'b1000);

        // exhaustive sweep
        for (int en = 0; en < 64; en++) begin
            cfg_write(6'(en));
            check("R2 readback", 8'(cfg_rdata_o), 8'(en));
            for (int iv = 0; iv < 4; iv++) begin
                for (int rq = 0; rq < 8; rq++) begin
                    prev = gnt_o;
                    req_i = 3'(rq); irq_i = iv[0]; fiq_i = iv[1]; ready_i = 1'b0;
                    @(negedge clk_i);
                    check("R4 hold without ready", 8'(gnt_o), 8'(prev));
                    ready_i = 1'b1;
                    @(negedge clk_i);
                    ready_i = 1'b0;
                    exp = model(6'(en), iv[0], iv[1], 3'(rq));
                    m = (6'(en) & 6'({3{iv[0]}} | ({3{iv[1]}} << 3))) != 0 ?
                        ((3'(en) & {3{iv[0]}}) | (3'(en >> 3) & {3{iv[1]}})) : 3'b000;
                    if (m == 3'b000)
                        check(exp[3] ? "R6 default" : "R5 priority", 8'(gnt_o), 8'(exp));
                    else if ((m & 3'(rq)) == 3'b000)
                        check("R10 other masters unaffected", 8'(gnt_o), 8'(exp));
                    else if (iv[0] && (3'(en) & 3'(rq)) != 0)
                        check("R7 irq gating", 8'(gnt_o), 8'(exp));
                    else
                        check("R8 fiq gating", 8'(gnt_o), 8'(exp));
                    check("R3 onehot", 8'($countones(gnt_o)), 8'd1);
                end
            end
        end

        // targeted degrant and release: DMA holds bus, gated by irq
        irq_i = 1'b0; fiq_i = 1'b0;
        cfg_write(6'b000001);
        req_i = 3'b101; ready_i = 1'b1;
        @(negedge clk_i);
        check("R5 DMA wins", 8'(gnt_o), 8'b0001);
        irq_i = 1'b1; ready_i = 1'b0;
        @(negedge clk_i);
        check("R4 no degrant mid-beat", 8'(gnt_o), 8'b0001);
        ready_i = 1'b1;
        @(negedge clk_i);
        check("R7 degrant to USB", 8'(gnt_o), 8'b0100);
        @(negedge clk_i);
        check("R7 lockout persists", 8'(gnt_o), 8'b0100);
        irq_i = 1'b0;
        @(negedge clk_i);
        check("R9 release", 8'(gnt_o), 8'b0001);

        // fast interrupt gating MAC alone, release to MAC
        cfg_write(6'b010000);
        req_i = 3'b010; fiq_i = 1'b1; ready_i = 1'b1;
        @(negedge clk_i);
        check("R8 MAC gated to cpu", 8'(gnt_o), 8'b1000);
        fiq_i = 1'b0;
        @(negedge clk_i);
        check("R9 MAC released", 8'(gnt_o), 8'b0010);
        ready_i = 1'b0;
        finish_run();
    end
endmodule